// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block walks the addresses of one bus burst, one beat at a time. A one-cycle `start` pulse loads a start address, a 3-bit burst kind and a 3-bit transfer-size code. After that, each cycle in which the consumer raises both `advance` and `ready` accepts the current beat and moves `addr` to the next beat's address. Incrementing kinds step by the beat size. Wrapping kinds fold back inside an aligned window whose size is the beat size times the beat count.

The generator checks the start request before it opens a burst. It rejects a start address that is not aligned to the beat size, and a size code larger than the widest beat it supports. It also rejects a fixed-length incrementing burst whose last byte would fall past the next 1 KB boundary. A rejected request raises a sticky flag and leaves the generator idle.

For fixed-length kinds, `last_beat` marks the final beat. An unspecified-length burst runs until the `stop` input ends it. `stop` also cuts any burst short.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `last_beat`, `align_err` and `bound_err` are 0 and `addr` is 0.
- R2: A `start` pulse loads `addr` with `start_addr` in the next cycle and raises `busy`, provided the request is legal. The `burst_type` codes are 000 single, 001 unspecified-length incrementing, 010 wrap-4, 011 incr-4, 100 wrap-8, 101 incr-8, 110 wrap-16 and 111 incr-16.
- R3: In incrementing kinds, each accepted beat adds 2^`xfer_size` bytes to `addr`. Size code 000 is a byte, 001 a halfword and 010 a word.
- R4: In wrapping kinds, the address stays inside the aligned window of (2^`xfer_size` × beats) bytes that holds the start address. Only the bits below the window size change, and the step wraps from the top of the window to its base. A word wrap-4 burst from 0x34 gives 0x34, 0x38, 0x3C, 0x30.
- R5: A cycle in which `advance` or `ready` is low accepts no beat, and `addr` holds its value.
- R6: A single burst has 1 beat; the fixed kinds have 4, 8 or 16. `last_beat` is high exactly while the final beat is presented. Accepting that beat clears `busy`.
- R7: `last_beat` is never raised for an unspecified-length burst. `stop` while `busy` clears `busy` in the next cycle, accepts no beat in that cycle and leaves `addr` unchanged. This applies to every burst kind.
- R8: A start address with any bit below the beat size set, or a size code above 010, sets `align_err`. In that case `busy` stays low.
- R9: A fixed-length incrementing kind (011, 101, 111) is rejected when its start offset within the 1 KB page plus beats × bytes exceeds 1024. The rejection sets `bound_err` and keeps `busy` low. Ending exactly on the boundary is legal, and wrapping and single kinds are never flagged.
- R10: Both error flags hold until the next `start`, which recomputes them. `start` takes priority over `stop` and `advance`: in a cycle where they coincide, the new burst is loaded and no beat of the old one is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load a new burst request |
| start_addr | input | 32 | First beat address |
| burst_type | input | 3 | Burst kind code |
| xfer_size | input | 3 | Log2 of bytes per beat |
| advance | input | 1 | Consumer wants to take the current beat |
| ready | input | 1 | Current beat may complete this cycle |
| stop | input | 1 | End the running burst |
| addr | output | 32 | Address of the current beat |
| busy | output | 1 | A burst is in progress |
| last_beat | output | 1 | Current beat is the final one of a fixed-length burst |
| align_err | output | 1 | Last request was misaligned or had an illegal size |
| bound_err | output | 1 | Last request would cross a 1 KB boundary |

## Verification
Two pairs of functions can fall in the same cycle. The first is a new `start` arriving while a beat of the running burst is being accepted. The bench drives `start`, `advance` and `ready` high together in the middle of an incr-4 burst. It then checks that the new wrap-4 address appears, and that its beat count restarts so that `last_beat` rises only on the fourth new beat. The second pair is `stop` arriving with an accepted beat. The bench checks that the burst ends and that the address does not move.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
   typedef enum logic [2:0] {
      BK_SINGLE = 3'b000,
      BK_INCR   = 3'b001,
      BK_WRAP4  = 3'b010,
      BK_INCR4  = 3'b011,
      BK_WRAP8  = 3'b100,
      BK_INCR8  = 3'b101,
      BK_WRAP16 = 3'b110,
      BK_INCR16 = 3'b111
   } burst_kind_e;

   localparam int BEAT_W = 5;   // holds beat counts 0..16
   localparam int CNT_W  = 4;   // beat index 0..15
endpackage

// File: rtl/burst_kind_decode.sv
module burst_kind_decode
   import burst_addr_pkg::*;
(
   input  logic [2:0]        kind,
   output logic [BEAT_W-1:0] beats,
   output logic              is_wrap,
   output logic              is_fixed,
   output logic              is_incr_fixed
);
   always_comb begin
      beats         = '0;
      is_wrap       = 1'b0;
      is_fixed      = 1'b1;
      is_incr_fixed = 1'b0;
      case (burst_kind_e'(kind))
         BK_SINGLE: beats = BEAT_W'(1);
         BK_INCR:   is_fixed = 1'b0;
         BK_WRAP4:  begin beats = BEAT_W'(4);  is_wrap = 1'b1; end
         BK_INCR4:  begin beats = BEAT_W'(4);  is_incr_fixed = 1'b1; end
         BK_WRAP8:  begin beats = BEAT_W'(8);  is_wrap = 1'b1; end
         BK_INCR8:  begin beats = BEAT_W'(8);  is_incr_fixed = 1'b1; end
         BK_WRAP16: begin beats = BEAT_W'(16); is_wrap = 1'b1; end
         default:   begin beats = BEAT_W'(16); is_incr_fixed = 1'b1; end
      endcase
   end
endmodule

// File: rtl/burst_start_check.sv
module burst_start_check
   import burst_addr_pkg::*;
#(
   parameter int MAX_SIZE    = 2,
   parameter int BOUND_BITS  = 10,
   parameter bit BOUND_CHECK = 1'b1,
   localparam int MASK_W     = MAX_SIZE + 4,
   localparam int LOW_W      = (BOUND_BITS > MASK_W) ? BOUND_BITS : MASK_W
)(
   input  logic [LOW_W-1:0]  addr_low,
   input  logic [2:0]        size,
   input  logic [BEAT_W-1:0] beats,
   input  logic              is_incr_fixed,
   output logic              align_bad,
   output logic              bound_bad,
   output logic [MASK_W-1:0] win_mask
);
   localparam int SPAN_W = MASK_W + 1;
   localparam int SUM_W  = LOW_W + 2;

   logic              size_ok;
   logic [MASK_W-1:0] bytes_m;
   logic [SPAN_W-1:0] span;

   assign size_ok   = (int'(size) <= MAX_SIZE);
   assign bytes_m   = size_ok ? (MASK_W'(1) << size) : '0;
   assign align_bad = !size_ok || ((addr_low[MASK_W-1:0] & (bytes_m - MASK_W'(1))) != '0);
   assign span      = SPAN_W'(bytes_m) * SPAN_W'(beats);
   // window is a power of two; a full-width window gives an all-ones mask
   assign win_mask  = span[MASK_W-1:0] - MASK_W'(1);

   generate
      if (BOUND_CHECK) begin : g_bound
         logic [SUM_W-1:0] end_off;
         assign end_off   = SUM_W'(addr_low[BOUND_BITS-1:0]) + SUM_W'(span);
         assign bound_bad = is_incr_fixed && (end_off > SUM_W'(2 ** BOUND_BITS));
      end else begin : g_nobound
         assign bound_bad = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr #(
   parameter int AW       = 32,
   parameter int MAX_SIZE = 2,
   localparam int MASK_W  = MAX_SIZE + 4
)(
   input  logic [AW-1:0]     cur,
   input  logic [2:0]        size,
   input  logic [MASK_W-1:0] win_mask,
   input  logic              is_wrap,
   output logic [AW-1:0]     nxt
);
   logic [AW-1:0] step, incr, mask_ext;

   assign step     = AW'(1) << size;
   assign incr     = cur + step;
   assign mask_ext = AW'(win_mask);
   assign nxt      = is_wrap ? ((cur & ~mask_ext) | (incr & mask_ext)) : incr;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_addr_pkg::*;
#(
   parameter int AW          = 32,
   parameter int MAX_SIZE    = 2,
   parameter int BOUND_BITS  = 10,
   parameter bit BOUND_CHECK = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic [2:0]    burst_type,
   input  logic [2:0]    xfer_size,
   input  logic          advance,
   input  logic          ready,
   input  logic          stop,
   output logic [AW-1:0] addr,
   output logic          busy,
   output logic          last_beat,
   output logic          align_err,
   output logic          bound_err
);
   localparam int MASK_W = MAX_SIZE + 4;
   localparam int LOW_W  = (BOUND_BITS > MASK_W) ? BOUND_BITS : MASK_W;

   generate
      if (AW <= LOW_W) begin : g_bad_aw
         $error("burst_addr_gen: AW must exceed the page and window widths");
      end
      if (MAX_SIZE < 0 || MAX_SIZE > 7) begin : g_bad_size
         $error("burst_addr_gen: MAX_SIZE out of range 0..7");
      end
   endgenerate

   logic [BEAT_W-1:0] dec_beats;
   logic              dec_wrap, dec_fixed, dec_incr_fixed;
   logic              align_bad, bound_bad;
   logic [MASK_W-1:0] new_mask;
   logic [AW-1:0]     nxt_addr;

   logic [AW-1:0]     addr_q;
   logic [2:0]        size_q;
   logic [BEAT_W-1:0] beats_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [MASK_W-1:0] mask_q;
   logic              wrap_q, fixed_q, busy_q, align_q, bound_q;
   logic              accept;

   burst_kind_decode u_dec (
      .kind          (burst_type),
      .beats         (dec_beats),
      .is_wrap       (dec_wrap),
      .is_fixed      (dec_fixed),
      .is_incr_fixed (dec_incr_fixed)
   );

   burst_start_check #(
      .MAX_SIZE    (MAX_SIZE),
      .BOUND_BITS  (BOUND_BITS),
      .BOUND_CHECK (BOUND_CHECK)
   ) u_chk (
      .addr_low      (start_addr[LOW_W-1:0]),
      .size          (xfer_size),
      .beats         (dec_beats),
      .is_incr_fixed (dec_incr_fixed),
      .align_bad     (align_bad),
      .bound_bad     (bound_bad),
      .win_mask      (new_mask)
   );

   burst_next_addr #(
      .AW       (AW),
      .MAX_SIZE (MAX_SIZE)
   ) u_nxt (
      .cur      (addr_q),
      .size     (size_q),
      .win_mask (mask_q),
      .is_wrap  (wrap_q),
      .nxt      (nxt_addr)
   );

   // priority: start, then stop, then beat acceptance
   assign accept    = busy_q && advance && ready && !start && !stop;
   assign last_beat = busy_q && fixed_q && (BEAT_W'(cnt_q) == beats_q - BEAT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         size_q  <= '0;
         beats_q <= '0;
         cnt_q   <= '0;
         mask_q  <= '0;
         wrap_q  <= 1'b0;
         fixed_q <= 1'b0;
         busy_q  <= 1'b0;
         align_q <= 1'b0;
         bound_q <= 1'b0;
      end else if (start) begin
         addr_q  <= start_addr;
         size_q  <= xfer_size;
         beats_q <= dec_beats;
         cnt_q   <= '0;
         mask_q  <= new_mask;
         wrap_q  <= dec_wrap;
         fixed_q <= dec_fixed;
         align_q <= align_bad;
         bound_q <= bound_bad;
         busy_q  <= !(align_bad || bound_bad);
      end else if (busy_q && stop) begin
         busy_q <= 1'b0;
      end else if (accept) begin
         addr_q <= nxt_addr;
         cnt_q  <= cnt_q + CNT_W'(1);
         if (last_beat) busy_q <= 1'b0;
      end
   end

   assign addr      = addr_q;
   assign busy      = busy_q;
   assign align_err = align_q;
   assign bound_err = bound_q;

   // R2: a start loads the requested address
   p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> addr_q == $past(start_addr));

   // R3: incrementing step equals the beat size
   p_incr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !wrap_q) |=> addr_q == $past(addr_q) + (AW'(1) << $past(size_q)));

   // R4: wrapping keeps every bit above the window
   p_wrap_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && wrap_q) |=> ((addr_q ^ $past(addr_q)) & ~AW'($past(mask_q))) == '0);

   // R5: no accepted beat, no address movement
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !accept) |=> $stable(addr_q));

   // R6: taking the final beat ends the burst
   p_last_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (last_beat && accept) |=> !busy_q);

   // R7: stop ends a running burst
   p_stop_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && stop && !start) |=> !busy_q);

   // R8/R9: a rejected request never runs
   p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (align_q || bound_q) |-> !busy_q);
endmodule

// File: tb/burst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, advance = 1'b0, ready = 1'b0, stop = 1'b0;
   logic [31:0] start_addr = '0;
   logic [2:0]  burst_type = '0, xfer_size = '0;
   logic [31:0] addr;
   logic        busy, last_beat, align_err, bound_err;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   burst_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .burst_type(burst_type), .xfer_size(xfer_size), .advance(advance),
      .ready(ready), .stop(stop), .addr(addr), .busy(busy),
      .last_beat(last_beat), .align_err(align_err), .bound_err(bound_err)
   );

   typedef struct packed {
      logic [31:0] sa;
      logic [2:0]  ty;
      logic [2:0]  sz;
      logic [4:0]  nb;
      logic [31:0] second;
      logic [31:0] final_a;
      logic        ea;
      logic        eb;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      '{32'h34,  3'b010, 3'd2, 5'd4,  32'h38,  32'h30,  1'b0, 1'b0},
      '{32'h34,  3'b100, 3'd2, 5'd8,  32'h38,  32'h30,  1'b0, 1'b0},
      '{32'h34,  3'b101, 3'd1, 5'd8,  32'h36,  32'h42,  1'b0, 1'b0},
      '{32'h38,  3'b011, 3'd2, 5'd4,  32'h3C,  32'h44,  1'b0, 1'b0},
      '{32'h100, 3'b000, 3'd0, 5'd1,  32'h0,   32'h100, 1'b0, 1'b0},
      '{32'h1F,  3'b110, 3'd0, 5'd16, 32'h10,  32'h1E,  1'b0, 1'b0},
      '{32'h3F8, 3'b011, 3'd2, 5'd4,  32'h0,   32'h0,   1'b0, 1'b1},
      '{32'h3F0, 3'b011, 3'd2, 5'd4,  32'h3F4, 32'h3FC, 1'b0, 1'b0},
      '{32'h36,  3'b011, 3'd2, 5'd4,  32'h0,   32'h0,   1'b1, 1'b0},
      '{32'h3F8, 3'b010, 3'd2, 5'd4,  32'h3FC, 32'h3F4, 1'b0, 1'b0},
      '{32'h40,  3'b010, 3'd3, 5'd4,  32'h0,   32'h0,   1'b1, 1'b0},
      '{32'h3FE, 3'b000, 3'd1, 5'd1,  32'h0,   32'h3FE, 1'b0, 1'b0},
      '{32'h3C,  3'b111, 3'd2, 5'd16, 32'h40,  32'h78,  1'b0, 1'b0}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // tasks are entered and left at a falling edge
   task automatic start_burst(input logic [31:0] a, input logic [2:0] t, input logic [2:0] s);
      start = 1'b1; start_addr = a; burst_type = t; xfer_size = s;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic step();
      advance = 1'b1; ready = 1'b1;
      @(negedge clk);
      advance = 1'b0; ready = 1'b0;
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state in and just after reset
      chk(!busy && !last_beat && !align_err && !bound_err && addr == 0, "R1", addr, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !last_beat && !align_err && !bound_err && addr == 0, "R1", {busy, last_beat}, 0);

      for (int i = 0; i < NV; i++) begin
         start_burst(TBL[i].sa, TBL[i].ty, TBL[i].sz);
         if (TBL[i].ea || TBL[i].eb) begin
            chk(align_err == TBL[i].ea, "R8", align_err, TBL[i].ea);
            chk(bound_err == TBL[i].eb, "R9", bound_err, TBL[i].eb);
            chk(!busy, "R8", busy, 0);
            step();
            chk(!busy && addr == TBL[i].sa, "R10", addr, TBL[i].sa);
         end else begin
            chk(busy && addr == TBL[i].sa, "R2", addr, TBL[i].sa);
            chk(!align_err && !bound_err, "R9", {align_err, bound_err}, 0);
            for (int b = 0; b < int'(TBL[i].nb) - 1; b++) begin
               chk(!last_beat, "R6", last_beat, 0);
               step();
               if (b == 0)
                  chk(addr == TBL[i].second, TBL[i].ty[0] ? "R3" : "R4", addr, TBL[i].second);
            end
            chk(addr == TBL[i].final_a, TBL[i].ty[0] ? "R3" : "R4", addr, TBL[i].final_a);
            chk(last_beat, "R6", last_beat, 1);
            step();
            chk(!busy && !last_beat, "R6", busy, 0);
         end
      end

      // R5: wait states hold the address
      start_burst(32'h0, 3'b011, 3'd2);
      advance = 1'b1; ready = 1'b0; @(negedge clk);
      chk(addr == 0, "R5", addr, 0);
      advance = 1'b0; ready = 1'b1; @(negedge clk);
      ready = 1'b0;
      chk(addr == 0, "R5", addr, 0);
      step();
      chk(addr == 4, "R5", addr, 4);

      // R10: new start coincides with an accepted beat
      start = 1'b1; start_addr = 32'h200; burst_type = 3'b010; xfer_size = 3'd2;
      advance = 1'b1; ready = 1'b1;
      @(negedge clk);
      start = 1'b0; advance = 1'b0; ready = 1'b0;
      chk(busy && addr == 32'h200 && !last_beat, "R10", addr, 32'h200);
      step(); step(); step();
      chk(addr == 32'h20C && last_beat, "R10", addr, 32'h20C);
      step();
      chk(!busy, "R10", busy, 0);

      // R7: unspecified length, then stop with a beat offered
      start_burst(32'h5C, 3'b001, 3'd2);
      chk(!last_beat, "R7", last_beat, 0);
      step();
      chk(addr == 32'h60 && !last_beat, "R7", addr, 32'h60);
      step();
      chk(addr == 32'h64 && !last_beat, "R7", addr, 32'h64);
      stop = 1'b1; advance = 1'b1; ready = 1'b1;
      @(negedge clk);
      stop = 1'b0; advance = 1'b0; ready = 1'b0;
      chk(!busy && addr == 32'h64, "R7", addr, 32'h64);
      step();
      chk(addr == 32'h64, "R7", addr, 32'h64);

      // R7: stop cuts a fixed wrapping burst short
      start_burst(32'h0, 3'b100, 3'd2);
      step();
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      chk(!busy && !last_beat && addr == 4, "R7", addr, 4);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule